// File: doc/BRIEF.md
# Audio Switching Control Register Bank

This block is a write-only two-wire serial slave that holds the control settings of a multi-output audio switching and tone-control device. A host addresses it, sends one subaddress byte, and then streams data bytes. Each data byte lands in one of ten byte-wide control registers, and the subaddress steps forward by one after every byte. Every stored field drives a parallel output. These outputs are input-source codes for the headphone, SCART and loudspeaker paths, three mute flags, the effect bits and a decoded sound mode, the loudspeaker common, balance, bass and treble codes, the two headphone volume codes, and two general-purpose port levels.

SCL and SDA are sampled with the system clock through a synchronizer. The block detects START and STOP itself and never stretches the clock. SDA is open-drain: the block only signals when it pulls the line low. A strap input picks the low address bit, so two of these banks can share one bus. A synchronous power-on reset leaves every output path muted.

Top module: `audctl_i2c_regs`

## Requirements
- R1: The block acknowledges an address byte only when it equals 0x80 with `addr_sel` low, or 0x82 with `addr_sel` high. Any other address byte, including any byte with the read bit (bit 0) set, gets no acknowledge. After such a byte the block ignores the bus until the next START.
- R2: After an acknowledged address byte, the first byte is taken as the subaddress and is acknowledged. Each later byte is a data byte, is acknowledged, and is written on the rising SCL edge of its own acknowledge clock.
- R3: Each data byte after the first goes to the subaddress one above the previous byte's subaddress.
- R4: Data bytes aimed at a subaddress above 0x09 are acknowledged but change no register. This covers a starting subaddress above 0x09 and an increment that runs past 0x09.
- R5: Register map, MSB first. 0x00: speaker common volume [5:0]. 0x01/0x02: left/right balance [4:0]. 0x03: bass [4:0]. 0x04: treble [3:0]. 0x05/0x06: headphone left/right volume [5:0]. 0x07: {0, hp_mute, 0, 0, hp_src[3:0]}. 0x08: {0, scart_mute, port_a, port_b, scart_src[3:0]}. 0x09: {fx2, spk_mute, fx1, fx0, spk_src[3:0]}. `fx_bits` = {fx2, fx1, fx0}.
- R6: Reset sets hp_mute, scart_mute and spk_mute to 1 and every other field to 0. Writing 0 to a mute bit clears that mute.
- R7: Bit positions that are not named in R5 always read as zero, whatever value was written to them.
- R8: `sound_mode` is decoded from {fx2, fx1, fx0}. With fx0 = 1: 2 (plain stereo) when fx1 = 0, 3 (30% spatial) when fx1 = 1 and fx2 = 0, 4 (52% spatial) when fx1 = 1 and fx2 = 1. With fx0 = 0: 1 (pseudo stereo) when fx1 = 1, else 0 (mono).
- R9: `port_a` and `port_b` equal register 0x08 bits 5 and 4: 0 gives a low level, 1 a high level.
- R10: A data byte cut short by a STOP or by a repeated START is dropped and writes nothing.
- R11: `sda_pull` is asserted only during the acknowledge slot of an acknowledged byte. It is released on the next SCL fall and by a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| addr_sel | input | 1 | Strap selecting the low address bit |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain) |
| spk_vol | output | 6 | Speaker common volume code |
| spk_bal_l | output | 5 | Speaker left balance code |
| spk_bal_r | output | 5 | Speaker right balance code |
| spk_bass | output | 5 | Bass code |
| spk_treble | output | 4 | Treble code |
| hp_vol_l | output | 6 | Headphone left volume code |
| hp_vol_r | output | 6 | Headphone right volume code |
| hp_src | output | 4 | Headphone input-source code |
| scart_src | output | 4 | SCART input-source code |
| spk_src | output | 4 | Speaker input-source code |
| hp_mute | output | 1 | Headphone mute |
| scart_mute | output | 1 | SCART mute |
| spk_mute | output | 1 | Speaker mute |
| fx_bits | output | 3 | Raw effect bits {fx2, fx1, fx0} |
| sound_mode | output | 3 | Decoded sound mode (R8) |
| port_a | output | 1 | General-purpose port level A |
| port_b | output | 1 | General-purpose port level B |

## Verification
The bench builds the block with its default two-stage synchronizer and a bus quarter-period of four system clocks. This short byte time makes an exhaustive sweep affordable: all 256 address bytes under both strap values. It also covers every one of the eight effect-bit combinations and all four port-bit pairs. Bursts of all-ones, all-zeros and an index-derived pattern over the whole ten-register map expose every field position and every reserved bit. Short bursts near the top of the map reach the increment overflow, and cut-off bytes reach the STOP and repeated-START discard paths.

// File: rtl/audctl_pkg.sv
package audctl_pkg;

    localparam int NUM_REGS = 10;
    localparam int IDX_W    = $clog2(NUM_REGS + 1);
    localparam logic [5:0] DEV_ADDR_HI = 6'b100000;
    localparam int MUTE_BIT = 6;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_ADDR,
        XS_SUB,
        XS_DATA
    } xfer_state_e;

    typedef enum logic [2:0] {
        SND_MONO   = 3'd0,
        SND_PSEUDO = 3'd1,
        SND_STEREO = 3'd2,
        SND_SPAT30 = 3'd3,
        SND_SPAT52 = 3'd4
    } sound_mode_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } reg_wr_t;

    function automatic logic [7:0] field_mask(input int idx);
        case (idx)
            0, 5, 6:  return 8'h3F;
            1, 2, 3:  return 8'h1F;
            4:        return 8'h0F;
            7:        return 8'h4F;
            8:        return 8'h7F;
            9:        return 8'hFF;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reset_value(input int idx);
        if (idx >= 7 && idx <= 9)
            return 8'h01 << MUTE_BIT;
        return 8'h00;
    endfunction

    function automatic sound_mode_e decode_mode(input logic fx2, input logic fx1,
                                                input logic fx0);
        if (fx0) begin
            if (!fx1)
                return SND_STEREO;
            return fx2 ? SND_SPAT52 : SND_SPAT30;
        end
        return fx1 ? SND_PSEUDO : SND_MONO;
    endfunction

endpackage

// File: rtl/i2c_line_sense.sv
module i2c_line_sense
    import audctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_prev;
    logic                   sda_prev;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_in;
                    sda_sh <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
                    sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_sh[LAST];
            sda_prev <= sda_sh[LAST];
        end
    end

    always_comb begin
        evt.scl      = scl_sh[LAST];
        evt.sda      = sda_sh[LAST];
        evt.scl_rise = scl_sh[LAST] && !scl_prev;
        evt.scl_fall = !scl_sh[LAST] && scl_prev;
        evt.start    = scl_sh[LAST] && scl_prev && sda_prev && !sda_sh[LAST];
        evt.stop     = scl_sh[LAST] && scl_prev && !sda_prev && sda_sh[LAST];
    end

endmodule

// File: rtl/i2c_write_engine.sv
module i2c_write_engine
    import audctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    input  logic     addr_sel,
    output logic     sda_pull,
    output reg_wr_t  wr
);

    xfer_state_e      state;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic             in_ack;
    logic [IDX_W-1:0] ptr;
    logic             addr_hit;
    logic             ptr_valid;

    assign addr_hit  = (shreg == {DEV_ADDR_HI, addr_sel, 1'b0});
    assign ptr_valid = (ptr < IDX_W'(NUM_REGS));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= XS_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            in_ack   <= 1'b0;
            sda_pull <= 1'b0;
            ptr      <= IDX_W'(NUM_REGS);
            wr       <= '0;
        end else begin
            wr.en <= 1'b0;
            if (evt.start) begin
                state    <= XS_ADDR;
                bit_cnt  <= '0;
                in_ack   <= 1'b0;
                sda_pull <= 1'b0;
            end else if (evt.stop) begin
                state    <= XS_IDLE;
                bit_cnt  <= '0;
                in_ack   <= 1'b0;
                sda_pull <= 1'b0;
            end else if (state != XS_IDLE) begin
                if (!in_ack) begin
                    if (evt.scl_rise && bit_cnt < 4'd8) begin
                        shreg   <= {shreg[6:0], evt.sda};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (evt.scl_fall && bit_cnt == 4'd8) begin
                        case (state)
                            XS_ADDR: begin
                                if (addr_hit) begin
                                    in_ack   <= 1'b1;
                                    sda_pull <= 1'b1;
                                end else begin
                                    state <= XS_IDLE;
                                end
                            end
                            XS_SUB: begin
                                in_ack   <= 1'b1;
                                sda_pull <= 1'b1;
                                ptr      <= (shreg < 8'(NUM_REGS)) ? shreg[IDX_W-1:0]
                                                                   : IDX_W'(NUM_REGS);
                            end
                            default: begin
                                in_ack   <= 1'b1;
                                sda_pull <= 1'b1;
                            end
                        endcase
                    end
                end else begin
                    if (evt.scl_rise && state == XS_DATA && ptr_valid) begin
                        wr.en   <= 1'b1;
                        wr.idx  <= ptr;
                        wr.data <= shreg;
                        ptr     <= ptr + IDX_W'(1);
                    end
                    if (evt.scl_fall) begin
                        in_ack   <= 1'b0;
                        sda_pull <= 1'b0;
                        bit_cnt  <= '0;
                        if (state == XS_ADDR)
                            state <= XS_SUB;
                        else if (state == XS_SUB)
                            state <= XS_DATA;
                    end
                end
            end
        end
    end

    // R11: the pull starts only right after an SCL fall
    a_r11_pull_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> $past(evt.scl_fall));

    // R11: a STOP always frees the line
    a_r11_stop_releases: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !sda_pull);

    // R4: no write leaves the register map
    a_r4_write_in_map: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (wr.idx < IDX_W'(NUM_REGS)));

    // R2: a write follows an SCL rising edge
    a_r2_write_on_rise: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> $past(evt.scl_rise));

endmodule

// File: rtl/audctl_reg_bank.sv
module audctl_reg_bank
    import audctl_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  reg_wr_t                  wr,
    output logic [NUM_REGS-1:0][7:0] regs
);

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= reset_value(g);
                else if (wr.en && wr.idx == IDX_W'(g))
                    q <= wr.data & field_mask(g);
            end
            assign regs[g] = q;
        end
    endgenerate

    // R6: all three mutes are active as reset ends
    a_r6_mutes_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (regs[7][MUTE_BIT] && regs[8][MUTE_BIT] && regs[9][MUTE_BIT]));

    // R4/R7: contents only move on a write strobe
    a_r7_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(regs));

endmodule

// File: rtl/audctl_i2c_regs.sv
module audctl_i2c_regs
    import audctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       addr_sel,
    output logic       sda_pull,
    output logic [5:0] spk_vol,
    output logic [4:0] spk_bal_l,
    output logic [4:0] spk_bal_r,
    output logic [4:0] spk_bass,
    output logic [3:0] spk_treble,
    output logic [5:0] hp_vol_l,
    output logic [5:0] hp_vol_r,
    output logic [3:0] hp_src,
    output logic [3:0] scart_src,
    output logic [3:0] spk_src,
    output logic       hp_mute,
    output logic       scart_mute,
    output logic       spk_mute,
    output logic [2:0] fx_bits,
    output logic [2:0] sound_mode,
    output logic       port_a,
    output logic       port_b
);

    bus_evt_t                 evt;
    reg_wr_t                  wr;
    logic [NUM_REGS-1:0][7:0] regs;
    sound_mode_e              mode;

    i2c_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_write_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .addr_sel (addr_sel),
        .sda_pull (sda_pull),
        .wr       (wr)
    );

    audctl_reg_bank u_bank (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .regs (regs)
    );

    always_comb begin
        spk_vol    = regs[0][5:0];
        spk_bal_l  = regs[1][4:0];
        spk_bal_r  = regs[2][4:0];
        spk_bass   = regs[3][4:0];
        spk_treble = regs[4][3:0];
        hp_vol_l   = regs[5][5:0];
        hp_vol_r   = regs[6][5:0];
        hp_src     = regs[7][3:0];
        scart_src  = regs[8][3:0];
        spk_src    = regs[9][3:0];
        hp_mute    = regs[7][MUTE_BIT];
        scart_mute = regs[8][MUTE_BIT];
        spk_mute   = regs[9][MUTE_BIT];
        port_a     = regs[8][5];
        port_b     = regs[8][4];
        fx_bits    = {regs[9][7], regs[9][5], regs[9][4]};
        mode       = decode_mode(regs[9][7], regs[9][5], regs[9][4]);
        sound_mode = mode;
    end

endmodule

// File: tb/audctl_i2c_regs_tb.sv
module audctl_i2c_regs_tb;

    localparam int Q = 4;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_line;
    logic sda_pull;
    logic [5:0] spk_vol, hp_vol_l, hp_vol_r;
    logic [4:0] spk_bal_l, spk_bal_r, spk_bass;
    logic [3:0] spk_treble, hp_src, scart_src, spk_src;
    logic hp_mute, scart_mute, spk_mute, port_a, port_b;
    logic [2:0] fx_bits, sound_mode;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [7:0] exp_r [10];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    audctl_i2c_regs u_dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .addr_sel(addr_sel),
        .sda_pull(sda_pull), .spk_vol(spk_vol), .spk_bal_l(spk_bal_l),
        .spk_bal_r(spk_bal_r), .spk_bass(spk_bass), .spk_treble(spk_treble),
        .hp_vol_l(hp_vol_l), .hp_vol_r(hp_vol_r), .hp_src(hp_src),
        .scart_src(scart_src), .spk_src(spk_src), .hp_mute(hp_mute),
        .scart_mute(scart_mute), .spk_mute(spk_mute), .fx_bits(fx_bits),
        .sound_mode(sound_mode), .port_a(port_a), .port_b(port_b)
    );

    function automatic logic [7:0] mask_of(input int i);
        case (i)
            0, 5, 6: return 8'h3F;
            1, 2, 3: return 8'h1F;
            4:       return 8'h0F;
            7:       return 8'h4F;
            8:       return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [2:0] mode_of(input logic [7:0] r9);
        if (r9[4]) return r9[5] ? (r9[7] ? 3'd4 : 3'd3) : 3'd2;
        return r9[5] ? 3'd1 : 3'd0;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input logic [63:0] got,
                       input logic [63:0] want);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h expected=%h", req, got, want);
        end
    endtask

    task automatic check_all(input string req);
        logic [63:0] got, want;
        got  = {spk_vol, spk_bal_l, spk_bal_r, spk_bass, spk_treble, hp_vol_l, hp_vol_r,
                hp_src, scart_src, spk_src, hp_mute, scart_mute, spk_mute, fx_bits,
                sound_mode, port_a, port_b, sda_pull};
        want = {exp_r[0][5:0], exp_r[1][4:0], exp_r[2][4:0], exp_r[3][4:0], exp_r[4][3:0],
                exp_r[5][5:0], exp_r[6][5:0], exp_r[7][3:0], exp_r[8][3:0], exp_r[9][3:0],
                exp_r[7][6], exp_r[8][6], exp_r[9][6],
                exp_r[9][7], exp_r[9][5], exp_r[9][4], mode_of(exp_r[9]),
                exp_r[8][5], exp_r[8][4], 1'b0};
        chk(got === want, req, got, want);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        acked = !sda_line;
        tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic model_write(input int idx, input logic [7:0] v);
        if (idx < 10) exp_r[idx] = v & mask_of(idx);
    endtask

    task automatic burst(input logic [7:0] sub, input logic [7:0] d [], input string req);
        logic a;
        bus_start();
        send_byte(8'h80 | {6'd0, addr_sel, 1'b0}, a);
        chk(a, req, 64'(a), 64'd1);
        send_byte(sub, a);
        chk(a, req, 64'(a), 64'd1);
        foreach (d[k]) begin
            send_byte(d[k], a);
            chk(a, req, 64'(a), 64'd1);
            model_write(int'(sub) + k, d[k]);
        end
        bus_stop();
        tick(4 * Q);
        check_all(req);
    endtask

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        bad++;
        total++;
        $display("FAIL watchdog got=%0d expected<%0d", cycles, WATCHDOG);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d [];
        for (int i = 0; i < 10; i++) exp_r[i] = (i >= 7) ? 8'h40 : 8'h00;
        tick(5);
        rst = 1'b0;
        tick(4);
        check_all("R6 reset");

        // R1: exhaustive address sweep under both strap values
        for (int s = 0; s < 2; s++) begin
            addr_sel = s[0];
            tick(Q);
            for (int ab = 0; ab < 256; ab++) begin
                bus_start();
                send_byte(ab[7:0], a);
                bus_stop();
                chk(a == (ab == (8'h80 | (s << 1))), "R1 addr", 64'(a), 64'(ab == (8'h80 | (s << 1))));
            end
        end
        check_all("R1 no write from sweep");

        // R1: read bit set, following bytes ignored
        addr_sel = 1'b0;
        bus_start();
        send_byte(8'h81, a);
        chk(!a, "R1 read nack", 64'(a), 64'd0);
        send_byte(8'h00, a);
        chk(!a, "R1 idle after nack", 64'(a), 64'd0);
        send_byte(8'h3F, a);
        bus_stop();
        tick(4 * Q);
        check_all("R1 regs unchanged");

        // R5/R7/R6: full bursts
        d = new[10];
        foreach (d[k]) d[k] = 8'hFF;
        burst(8'h00, d, "R7 all ones");
        foreach (d[k]) d[k] = 8'h00;
        burst(8'h00, d, "R6 unmute");
        foreach (d[k]) d[k] = 8'((k * 37 + 5) ^ 8'hA5);
        burst(8'h00, d, "R5 pattern");
        addr_sel = 1'b1;
        foreach (d[k]) d[k] = 8'((k * 91 + 17));
        burst(8'h00, d, "R3 strap high burst");
        addr_sel = 1'b0;

        // R4: increment overflow and out-of-map start
        d = new[4];
        d[0] = 8'h2A; d[1] = 8'h93; d[2] = 8'hFF; d[3] = 8'h77;
        burst(8'h08, d, "R4 overflow");
        d = new[2];
        d[0] = 8'h55; d[1] = 8'h12;
        burst(8'h0C, d, "R4 bad sub");

        // R8: every effect combination
        for (int e = 0; e < 8; e++) begin
            d = new[1];
            d[0] = {e[2], 1'b0, e[1], e[0], 4'h3};
            burst(8'h09, d, "R8 mode");
        end

        // R9: port levels
        for (int p = 0; p < 4; p++) begin
            d = new[1];
            d[0] = {2'b00, p[1], p[0], 4'h9};
            burst(8'h08, d, "R9 ports");
        end

        // R10: byte cut by STOP
        bus_start();
        send_byte(8'h80, a);
        send_byte(8'h00, a);
        send_byte(8'h15, a);
        model_write(0, 8'h15);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        bus_stop();
        tick(4 * Q);
        check_all("R10 stop discard");

        // R10: byte cut by repeated START
        bus_start();
        send_byte(8'h80, a);
        send_byte(8'h01, a);
        send_byte(8'h11, a);
        model_write(1, 8'h11);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_start();
        send_byte(8'h80, a);
        chk(a, "R10 restart addr", 64'(a), 64'd1);
        send_byte(8'h03, a);
        send_byte(8'h05, a);
        model_write(3, 8'h05);
        bus_stop();
        tick(4 * Q);
        check_all("R10 restart discard");
        check_all("R11 released at idle");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule